// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem control and modem status registers of a serial port peripheral. It samples four active-low line inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input passes through a synchronizer first. The CPU sees the current level of every line in the status register. It also sees a sticky change flag for every line.

The unit drives two active-low outputs, request-to-send and data-terminal-ready, from bits of the control register. When a change flag is set and the CPU has enabled it, the unit raises a modem interrupt request. A read strobe on the status register clears the flags and the request.

A loop bit in the control register gives a self-test path. While it is set, both line outputs stay inactive. The status levels are then taken from control bits instead of the pins.

Top module: `modem_line_unit`

## Requirements
- R1: Status bit 6 reads as the complement of the synchronized ring input, so it is 1 while `ring_n` is low. Status bits 4, 5 and 7 report clear-to-send, data-set-ready and carrier-detect in the same active-high sense.
- R2: Status bit 2 is set when the ring input has gone from low to high since the last status read. A high-to-low change of the ring input does not set it.
- R3: `irq` is high when `irq_en` is high and any of status bits 0 to 3 is set. `irq` is low whenever `irq_en` is low. A ring trailing edge therefore raises `irq` when `irq_en` is high.
- R4: With loop mode off, `rts_n` is the inverse of control bit 1 and `dtr_n` is the inverse of control bit 0.
- R5: After reset, the control register reads 0 and both `rts_n` and `dtr_n` are high. With all line inputs high, the status register reads 0 and `irq` is low.
- R6: While control bit 4 (loop) is set, `rts_n` and `dtr_n` are both high, whatever control bits 0 and 1 hold.
- R7: In loop mode, status bits 4, 5, 6 and 7 reflect control bits 1, 0, 2 and 3, and the four line inputs have no effect on the status register.
- R8: A change on a line input first shows in the status register after exactly `SYNC_STAGES` rising clock edges. With the default of 2, it is not yet visible after one edge.
- R9: Status bits 0, 1 and 3 latch any change, in either direction, of the clear-to-send, data-set-ready and carrier-detect levels.
- R10: A cycle with `msr_rd` high clears status bits 0 to 3, and with them `irq`, at the next edge. A change detected in the same cycle as the read stays set.
- R11: `mcr_q` reads back the five written control bits in bits 4 to 0, with bits 7 to 5 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| mcr_wr | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data for the control register |
| msr_rd | input | 1 | Read strobe of the status register; clears the change flags |
| irq_en | input | 1 | Modem interrupt enable |
| cts_n | input | 1 | Clear-to-send line, active low |
| dsr_n | input | 1 | Data-set-ready line, active low |
| ring_n | input | 1 | Ring indicator line, active low |
| dcd_n | input | 1 | Carrier-detect line, active low |
| mcr_q | output | 8 | Control register readback |
| msr_q | output | 8 | Status register: levels in bits 7:4, change flags in bits 3:0 |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| irq | output | 1 | Modem interrupt request |

## Verification
The hardest case to reach is a line change that is detected in the very cycle the CPU reads the status register. If the clear were given priority, the event would be lost.

The bench reaches this case by counting the synchronizer latency exactly. It drives a pin just after a falling edge and lets two rising edges pass, which makes the new level visible. It then holds the read strobe across the next edge, the one on which the flag is set, and checks that the flag survives.

The loop-mode test also uses exact timing. It first moves the pins while in loop mode and then confirms that no flag was raised.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int DATA_W   = 8;
   localparam int NLINES   = 4;
   localparam int CTRL_W   = 5;
   // line order: matches status levels (bits 4..7) and flags (bits 0..3)
   localparam int L_CTS    = 0;
   localparam int L_DSR    = 1;
   localparam int L_RING   = 2;
   localparam int L_DCD    = 3;
   // control register bit positions
   localparam int C_DTR    = 0;
   localparam int C_RTS    = 1;
   localparam int C_AUX1   = 2;
   localparam int C_AUX2   = 3;
   localparam int C_LOOP   = 4;
   // lines whose flag fires only on a falling status level
   localparam logic [NLINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int          WIDTH     = 4,
   parameter int          STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdm_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mdm_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= {WIDTH{RESET_VAL}};
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int                WIDTH = 4,
   parameter logic [WIDTH-1:0]  TRAIL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic             clr,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] prev;
   logic [WIDTH-1:0] evt;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_line
         if (TRAIL[i]) begin : g_trail
            assign evt[i] = prev[i] & ~lvl[i];
         end else begin : g_any
            assign evt[i] = prev[i] ^ lvl[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= '0;
         flags <= '0;
      end else begin
         prev  <= lvl;
         flags <= (flags & ~{WIDTH{clr}}) | evt;
      end
   end

   // R10: a read with no concurrent event leaves every flag clear
   p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (evt == '0)) |=> (flags == '0));
   // R10: a concurrent event is never lost to the read
   p_event_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mcr_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              msr_rd,
   input  logic              irq_en,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ring_n,
   input  logic              dcd_n,
   output logic [DATA_W-1:0] mcr_q,
   output logic [DATA_W-1:0] msr_q,
   output logic              rts_n,
   output logic              dtr_n,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CTRL_W;

   generate
      if (DATA_W != 2 * NLINES) begin : g_bad_layout
         $error("modem_line_unit: status layout needs DATA_W == 2*NLINES");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;
   logic [NLINES-1:0] pins_n, pins_s, lvl, loop_lvl, flags;
   logic              loop_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl <= '0;
      else if (mcr_wr) ctrl <= wr_data[CTRL_W-1:0];
   end

   assign loop_on = ctrl[C_LOOP];

   always_comb begin
      pins_n         = '0;
      pins_n[L_CTS]  = cts_n;
      pins_n[L_DSR]  = dsr_n;
      pins_n[L_RING] = ring_n;
      pins_n[L_DCD]  = dcd_n;
      loop_lvl         = '0;
      loop_lvl[L_CTS]  = ctrl[C_RTS];
      loop_lvl[L_DSR]  = ctrl[C_DTR];
      loop_lvl[L_RING] = ctrl[C_AUX1];
      loop_lvl[L_DCD]  = ctrl[C_AUX2];
   end

   mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_n),
      .q     (pins_s)
   );

   assign lvl = loop_on ? loop_lvl : ~pins_s;

   mdm_delta #(.WIDTH(NLINES), .TRAIL(TRAIL_ONLY)) u_delta (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .clr   (msr_rd),
      .flags (flags)
   );

   assign msr_q = {lvl, flags};
   assign mcr_q = {{PAD_W{1'b0}}, ctrl};
   assign rts_n = ~(ctrl[C_RTS] & ~loop_on);
   assign dtr_n = ~(ctrl[C_DTR] & ~loop_on);
   assign irq   = irq_en & (|flags);

   // R6: loop mode keeps both line outputs idle
   p_loop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      loop_on |-> (rts_n && dtr_n));
   // R4: a non-loop write drives rts_n from bit 1 on the next cycle
   p_rts_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mcr_wr && !wr_data[C_LOOP]) |=> (rts_n == !$past(wr_data[C_RTS])));
   // R2: a falling ring level sets the trailing-edge flag
   p_ring_trail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl[L_RING]) |=> msr_q[L_RING]);
   // R3: an enabled ring trailing edge raises the request
   p_irq_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && $fell(lvl[L_RING])) |=> (irq || !irq_en));
endmodule

// File: tb/modem_line_unit_tb_top.sv
module modem_line_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mcr_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       msr_rd = 1'b0;
   logic       irq_en = 1'b0;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ring_n = 1'b1, dcd_n = 1'b1;
   logic [7:0] mcr_q, msr_q;
   logic       rts_n, dtr_n, irq;
   int         n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   modem_line_unit dut_i (
      .clk(clk), .rst_n(rst_n), .mcr_wr(mcr_wr), .wr_data(wr_data),
      .msr_rd(msr_rd), .irq_en(irq_en), .cts_n(cts_n), .dsr_n(dsr_n),
      .ring_n(ring_n), .dcd_n(dcd_n), .mcr_q(mcr_q), .msr_q(msr_q),
      .rts_n(rts_n), .dtr_n(dtr_n), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctrl(input logic [7:0] v);
      wr_data = v; mcr_wr = 1'b1; tick(1); mcr_wr = 1'b0;
   endtask

   task automatic read_status();
      msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R5 mcr", mcr_q, 8'h00);
      chk("R5 rts_n", {7'b0, rts_n}, 8'h01);
      chk("R5 dtr_n", {7'b0, dtr_n}, 8'h01);
      chk("R5 msr", msr_q, 8'h00);
      chk("R5 irq", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_outputs();
      write_ctrl(8'h03);
      chk("R4 rts_n low", {7'b0, rts_n}, 8'h00);
      chk("R4 dtr_n low", {7'b0, dtr_n}, 8'h00);
      chk("R11 readback", mcr_q, 8'h03);
      write_ctrl(8'hE2);
      chk("R4 dtr_n high", {7'b0, dtr_n}, 8'h01);
      chk("R4 rts_n still low", {7'b0, rts_n}, 8'h00);
      chk("R11 upper bits zero", mcr_q, 8'h02);
      write_ctrl(8'h00);
   endtask

   task automatic t_sync_and_flags();
      cts_n = 1'b0;
      tick(1);
      chk("R8 not after one edge", {7'b0, msr_q[4]}, 8'h00);
      tick(1);
      chk("R8 visible after two edges", {7'b0, msr_q[4]}, 8'h01);
      tick(2);
      chk("R9 cts flag", {7'b0, msr_q[0]}, 8'h01);
      chk("R3 irq off when disabled", {7'b0, irq}, 8'h00);
      irq_en = 1'b1; tick(1);
      chk("R3 irq on when enabled", {7'b0, irq}, 8'h01);
      read_status();
      chk("R10 read clears flag", {4'b0, msr_q[3:0]}, 8'h00);
      chk("R10 read clears irq", {7'b0, irq}, 8'h00);
      dsr_n = 1'b0; dcd_n = 1'b0; tick(4);
      chk("R1 levels", {4'b0, msr_q[7:4]}, 8'h0B);
      chk("R9 dsr and dcd flags", {4'b0, msr_q[3:0]}, 8'h0A);
      read_status();
      dsr_n = 1'b1; tick(4);
      chk("R9 rising-level change flagged", {4'b0, msr_q[3:0]}, 8'h02);
      read_status();
   endtask

   task automatic t_ring();
      ring_n = 1'b0; tick(4);
      chk("R1 ring level", {7'b0, msr_q[6]}, 8'h01);
      chk("R2 no flag on leading edge", {7'b0, msr_q[2]}, 8'h00);
      chk("R3 no irq on leading edge", {7'b0, irq}, 8'h00);
      ring_n = 1'b1; tick(4);
      chk("R1 ring level cleared", {7'b0, msr_q[6]}, 8'h00);
      chk("R2 trailing edge flag", {7'b0, msr_q[2]}, 8'h01);
      chk("R3 irq on trailing edge", {7'b0, irq}, 8'h01);
      read_status();
      chk("R10 ring flag cleared", {7'b0, msr_q[2]}, 8'h00);
   endtask

   task automatic t_read_race();
      cts_n = 1'b1;
      tick(2);
      msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
      chk("R10 event during read kept", {7'b0, msr_q[0]}, 8'h01);
      read_status();
      chk("R10 cleared by later read", {4'b0, msr_q[3:0]}, 8'h00);
   endtask

   task automatic t_loop();
      dcd_n = 1'b1; tick(4); read_status();
      write_ctrl(8'h1F);
      chk("R6 rts_n idle", {7'b0, rts_n}, 8'h01);
      chk("R6 dtr_n idle", {7'b0, dtr_n}, 8'h01);
      tick(3);
      chk("R7 all looped", {4'b0, msr_q[7:4]}, 8'h0F);
      read_status();
      write_ctrl(8'h12); tick(3);
      chk("R7 rts maps to bit4", {4'b0, msr_q[7:4]}, 8'h01);
      read_status();
      dsr_n = 1'b0; ring_n = 1'b0; tick(4);
      chk("R7 pins ignored levels", {4'b0, msr_q[7:4]}, 8'h01);
      chk("R7 pins ignored flags", {4'b0, msr_q[3:0]}, 8'h00);
      chk("R6 rts_n idle with bit set", {7'b0, rts_n}, 8'h01);
      dsr_n = 1'b1; ring_n = 1'b1;
      write_ctrl(8'h02);
      chk("R4 rts_n after loop exit", {7'b0, rts_n}, 8'h00);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_outputs();
      t_sync_and_flags();
      t_ring();
      t_read_race();
      t_loop();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule